// File: doc/BRIEF.md
# Gated Interval Timer

This block times a long stretch of process activity, such as the time spent boiling, from an 8-bit prescaled counter that advances only while an external level gate is high. The system clock is divided down by a prescaler whose default ratio is 64. Each prescaler tick moves the 8-bit counter up by one. When the counter rolls over from 255, hardware reloads it from a programmable value and sets an overflow flag. The same overflow also decrements a 16-bit interval counter.

A start pulse arms a run. It loads both counters, clears the done and overflow flags, enables the overflow interrupt and switches the heater output on. When the interval counter is used up, the block turns the heater off, withdraws the interrupt enable and raises a done flag. From then on the counters stay frozen until the next start. Software can clear the overflow flag by writing one to it, and it can rewrite the interrupt enable at any time.

With a reload value of 6, each overflow period holds 250 increments. With an interval value of 22500, a run then lasts 22500 such periods of gated time.

Top module: `gated_interval_timer`

## Requirements
- R1: While a run is active and `gate_i` is high, the prescaler sends one tick every DIV clock cycles. Each tick adds one to `count_o`. The prescaler phase is kept while the gate is low, so partial periods accumulate.
- R2: While `gate_i` is low, `count_o` does not change, except on a start.
- R3: A tick taken with `count_o` equal to 255 loads `count_o` with `reload_i` and sets `ovf_flag_o` on the next cycle.
- R4: Each overflow that finds `big_o` above 1 lowers `big_o` by exactly one.
- R5: An overflow that finds `big_o` at 1 or 0 sets `big_o` to 0, clears `heater_o` and `irq_en_o`, and sets `done_o`.
- R6: A start pulse takes priority over every other input. On the next cycle `big_o` equals `big_load_i` and `count_o` equals `reload_i`. `heater_o` and `irq_en_o` are 1, `done_o` and `ovf_flag_o` are 0, and the prescaler phase is cleared. A start during a run restarts it from full counts.
- R7: `irq_o` is high exactly when `ovf_flag_o` and `irq_en_o` are both high.
- R8: A one on `flag_clr_i` clears `ovf_flag_o` on the next cycle. An overflow in the same cycle wins and leaves the flag set.
- R9: A pulse on `irq_en_wr_i` copies `irq_en_wdata_i` into `irq_en_o`. The finishing overflow of R5 overrides that write.
- R10: Synchronous reset drives every output to 0, which includes turning the heater off.
- R11: When no run is active (`heater_o` low), `count_o` stays unchanged whatever `gate_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle start or restart pulse |
| gate_i | input | 1 | Level gate; counting is allowed only while high |
| reload_i | input | 8 | Value loaded into the counter on start and on overflow |
| big_load_i | input | 16 | Interval count loaded on start |
| irq_en_wr_i | input | 1 | Write strobe for the interrupt enable |
| irq_en_wdata_i | input | 1 | Value written to the interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count_o | output | 8 | Current 8-bit counter value |
| big_o | output | 16 | Remaining interval count |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_en_o | output | 1 | Overflow interrupt enable |
| irq_o | output | 1 | Interrupt request |
| heater_o | output | 1 | Controlled output, high while a run is active |
| done_o | output | 1 | Set when a run has completed |

## Verification
The bench builds the block with DIV = 4 and keeps the default 8-bit and 16-bit widths. With that divider, a full 256-step overflow period lasts about a thousand cycles. Reload values near 255 shorten it to a few ticks, so many overflows, completions of small interval values and a zero interval all fit in a short run. The gate is driven both with random patterns and with long low stretches. Together these show that the prescaler keeps its phase while the gate is low, and that an overflow which coincides with a flag clear or with an enable write is resolved in the stated order.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  // Counter sits at its top value, so the next step wraps.
  function automatic logic at_top8(input logic [7:0] v);
    return v == 8'hFF;
  endfunction

  // Interval counter is on its last period (or was loaded with zero).
  function automatic logic last_period(input logic [15:0] v);
    return v <= 16'd1;
  endfunction

  // Saturating decrement of the interval counter.
  function automatic logic [15:0] dec_sat(input logic [15:0] v);
    return (v == 16'd0) ? 16'd0 : v - 16'd1;
  endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = en && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (tick)   phase <= '0;
    else if (en)     phase <= phase + 1'b1;
  end
endmodule

// File: rtl/gpt_accum.sv
module gpt_accum
  import gpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  input  logic [7:0] reload,
  output logic [7:0] count,
  output logic       wrap_evt
);
  assign wrap_evt = step && at_top8(count);

  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (load || wrap_evt) count <= reload;
    else if (step)            count <= count + 8'd1;
  end
endmodule

// File: rtl/gpt_interval.sv
module gpt_interval
  import gpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] big_load,
  input  logic        ovf_evt,
  input  logic        ien_wr,
  input  logic        ien_wdata,
  input  logic        flag_clr,
  output logic [15:0] big,
  output logic        flag,
  output logic        ien,
  output logic        heater,
  output logic        done,
  output logic        finish_evt
);
  assign finish_evt = ovf_evt && last_period(big);

  always_ff @(posedge clk) begin
    if (rst) begin
      big <= '0; flag <= 1'b0; ien <= 1'b0; heater <= 1'b0; done <= 1'b0;
    end else if (start) begin
      big <= big_load; flag <= 1'b0; ien <= 1'b1; heater <= 1'b1; done <= 1'b0;
    end else begin
      if (ovf_evt)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (ovf_evt)       big <= dec_sat(big);
      if (finish_evt) begin
        ien <= 1'b0; heater <= 1'b0; done <= 1'b1;
      end else if (ien_wr) begin
        ien <= ien_wdata;
      end
    end
  end
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer #(
  parameter int DIV = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        gate_i,
  input  logic [7:0]  reload_i,
  input  logic [15:0] big_load_i,
  input  logic        irq_en_wr_i,
  input  logic        irq_en_wdata_i,
  input  logic        flag_clr_i,
  output logic [7:0]  count_o,
  output logic [15:0] big_o,
  output logic        ovf_flag_o,
  output logic        irq_en_o,
  output logic        irq_o,
  output logic        heater_o,
  output logic        done_o
);
  logic run_gate;   // counting allowed this cycle
  logic tick;       // prescaler period complete
  logic ovf_evt;    // counter wraps this cycle
  logic finish_evt; // last interval period ends this cycle

  assign run_gate = heater_o && gate_i && !start_i;

  gpt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(start_i), .en(run_gate), .tick(tick)
  );

  gpt_accum u_acc (
    .clk(clk), .rst(rst), .load(start_i), .step(tick),
    .reload(reload_i), .count(count_o), .wrap_evt(ovf_evt)
  );

  gpt_interval u_int (
    .clk(clk), .rst(rst), .start(start_i), .big_load(big_load_i),
    .ovf_evt(ovf_evt), .ien_wr(irq_en_wr_i), .ien_wdata(irq_en_wdata_i),
    .flag_clr(flag_clr_i), .big(big_o), .flag(ovf_flag_o), .ien(irq_en_o),
    .heater(heater_o), .done(done_o), .finish_evt(finish_evt)
  );

  assign irq_o = ovf_flag_o && irq_en_o;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        gate_i,
  input logic [7:0]  reload_i,
  input logic [15:0] big_load_i,
  input logic        flag_clr_i,
  input logic [7:0]  count_o,
  input logic [15:0] big_o,
  input logic        ovf_flag_o,
  input logic        irq_en_o,
  input logic        irq_o,
  input logic        heater_o,
  input logic        done_o,
  input logic        ovf_evt,
  input logic        finish_evt
);
  p_gate_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!gate_i && !start_i) |=> $stable(count_o));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!heater_o && !start_i) |=> $stable(count_o));

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !start_i) |=> (count_o == $past(reload_i)) && ovf_flag_o);

  p_big_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !start_i && big_o > 16'd1) |=> big_o == $past(big_o) - 16'd1);

  p_finish_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !start_i && big_o <= 16'd1) |=>
      (!heater_o && done_o && !irq_en_o && big_o == 16'd0));

  p_start_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (heater_o && irq_en_o && !done_o && !ovf_flag_o &&
                 count_o == $past(reload_i) && big_o == $past(big_load_i)));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_en_o) |-> !irq_o);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !ovf_evt && !start_i) |=> (!ovf_flag_o && !irq_o));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!heater_o && !done_o && !ovf_flag_o && !irq_en_o &&
             count_o == 8'd0 && big_o == 16'd0));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(heater_o && done_o));

  p_finish_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    finish_evt |-> ovf_evt);
endmodule

bind gated_interval_timer gpt_checker u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .gate_i(gate_i),
  .reload_i(reload_i), .big_load_i(big_load_i), .flag_clr_i(flag_clr_i),
  .count_o(count_o), .big_o(big_o), .ovf_flag_o(ovf_flag_o),
  .irq_en_o(irq_en_o), .irq_o(irq_o), .heater_o(heater_o), .done_o(done_o),
  .ovf_evt(ovf_evt), .finish_evt(finish_evt)
);

// File: tb/gated_interval_timer_test.sv
`timescale 1ns/1ps
module gated_interval_timer_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, start_i = 1'b0, gate_i = 1'b0;
  logic [7:0]  reload_i = 8'd6;
  logic [15:0] big_load_i = 16'd3;
  logic        irq_en_wr_i = 1'b0, irq_en_wdata_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0]  count_o;
  logic [15:0] big_o;
  logic        ovf_flag_o, irq_en_o, irq_o, heater_o, done_o;

  gated_interval_timer #(.DIV(DIV)) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference model
  int m_ph, m_cnt, m_big, m_flag, m_ien, m_heat, m_done;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_big = 0; m_flag = 0; m_ien = 0; m_heat = 0; m_done = 0;
    end else if (start_i) begin
      m_ph = 0; m_cnt = reload_i; m_big = big_load_i; m_flag = 0;
      m_ien = 1; m_heat = 1; m_done = 0;
    end else begin
      bit tk, ov;
      tk = 0; ov = 0;
      if (irq_en_wr_i) m_ien = irq_en_wdata_i;
      if (flag_clr_i)  m_flag = 0;
      if (m_heat == 1 && gate_i) begin
        m_ph = m_ph + 1;
        if (m_ph == DIV) begin m_ph = 0; tk = 1; end
      end
      if (tk) begin
        if (m_cnt == 255) begin ov = 1; m_cnt = reload_i; end
        else m_cnt = m_cnt + 1;
      end
      if (ov) begin
        m_flag = 1;
        if (m_big <= 1) begin m_big = 0; m_heat = 0; m_ien = 0; m_done = 1; end
        else m_big = m_big - 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, sampled on the falling edge
  always @(negedge clk) if (!rst && !finished) begin
    chk("R1 count", count_o, m_cnt);
    chk("R4 big", big_o, m_big);
    chk("R3 flag", ovf_flag_o, m_flag);
    chk("R5 heater", heater_o, m_heat);
    chk("R5 done", done_o, m_done);
    chk("R9 irq_en", irq_en_o, m_ien);
    chk("R7 irq", irq_o, (m_flag && m_ien) ? 1 : 0);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input logic [7:0] rl, input logic [15:0] bl);
    reload_i = rl; big_load_i = bl; start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic rand_gate(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      gate_i = ($urandom_range(0, 99) < pct);
      flag_clr_i = ($urandom_range(0, 9) == 0);
      cyc(1);
    end
    flag_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int hold;
    cyc(3);
    // R10: reset state
    chk("R10 count", count_o, 0); chk("R10 heater", heater_o, 0);
    chk("R10 done", done_o, 0); chk("R10 irq", irq_o, 0);
    rst = 1'b0;
    cyc(2);

    // R11: idle, gate high, nothing moves
    gate_i = 1'b1; cyc(20);
    chk("R11 idle count", count_o, 0);

    // R6: start
    do_start(8'd250, 16'd3);
    chk("R6 count", count_o, 250); chk("R6 big", big_o, 3);
    chk("R6 heater", heater_o, 1); chk("R6 irq_en", irq_en_o, 1);

    // R1: exactly DIV cycles per increment with gate high
    gate_i = 1'b1; cyc(DIV);
    chk("R1 one step", count_o, 251);

    // R2: gate low holds count and prescaler phase
    gate_i = 1'b1; cyc(2); gate_i = 1'b0;
    hold = count_o; cyc(25);
    chk("R2 hold", count_o, hold);
    gate_i = 1'b1; cyc(DIV - 2);
    chk("R1 phase kept", count_o, hold + 1);

    // R3/R4/R5: run to completion
    cyc(400);
    chk("R5 done", done_o, 1); chk("R5 heater", heater_o, 0);
    chk("R8 flag left set", ovf_flag_o, 1);
    // R8: clear flag
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R8 cleared", ovf_flag_o, 0);
    hold = count_o; cyc(30);
    chk("R11 after done", count_o, hold);

    // Random gate with short periods, restart mid-run (R6)
    do_start(8'd252, 16'd20);
    rand_gate(300, 60);
    chk("R6 running before restart", heater_o, 1);
    do_start(8'd240, 16'd5);
    chk("R6 restart big", big_o, 5); chk("R6 restart count", count_o, 240);

    // R9: enable writes during run, R7 follows
    irq_en_wr_i = 1'b1; irq_en_wdata_i = 1'b0; cyc(1); irq_en_wr_i = 1'b0;
    chk("R9 disabled", irq_en_o, 0);
    rand_gate(200, 70);
    irq_en_wr_i = 1'b1; irq_en_wdata_i = 1'b1; cyc(1); irq_en_wr_i = 1'b0;
    rand_gate(2000, 80);

    // Overflow every tick, zero interval (R5)
    do_start(8'd255, 16'd0);
    gate_i = 1'b1; cyc(DIV + 2);
    chk("R5 zero load done", done_o, 1); chk("R5 zero load big", big_o, 0);

    // Heavy random stress with flag clears and enable writes
    do_start(8'd254, 16'd40);
    for (int k = 0; k < 1500; k++) begin
      gate_i = ($urandom_range(0, 3) != 0);
      flag_clr_i = ($urandom_range(0, 4) == 0);
      irq_en_wr_i = ($urandom_range(0, 19) == 0);
      irq_en_wdata_i = $urandom_range(0, 1);
      cyc(1);
    end
    flag_clr_i = 1'b0; irq_en_wr_i = 1'b0;
    gate_i = 1'b1; cyc(800);
    chk("R5 stress done", done_o, 1);

    // R10: reset during a run
    do_start(8'd10, 16'd100);
    cyc(50);
    rst = 1'b1; cyc(1);
    chk("R10 heater off", heater_o, 0); chk("R10 big", big_o, 0);
    chk("R10 count", count_o, 0);
    rst = 1'b0; cyc(2);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule